// File: doc/BRIEF.md
# Serial Display Command Receiver

This block sits at the controller end of a write-only serial display link. The link has four wires: an active-low select, a serial clock, a data line and a line that marks each byte as a command or as pixel data. The block brings all four pins into the system clock domain and detects rising edges of the serial clock there. It assembles bytes most significant bit first. A byte marked as pixel data leaves the block at once as a one-cycle strobe. A byte marked as command goes to a small parser.

The parser is a two-state machine. In `P_OPCODE` it waits for an opcode. An opcode that takes no arguments acts at once. An opcode that takes arguments moves the machine to `P_ARGS` (transition "open"). `P_ARGS` collects the argument bytes into a staging buffer and returns to `P_OPCODE` in one of two ways:

- On the last argument (transition "commit"), the whole buffer is applied to the register bank in one step.
- On a byte marked as pixel data (transition "abort"), the pending command is dropped and that byte is passed out as pixel data.

The register bank holds the display configuration that downstream drive logic reads: window bounds, contrast, drive settings, the grey-level table and the display modes.

Top module: `disp_cmd_rx`

## Requirements
- R1: Serial data is taken on rising edges of `ser_clk`, most significant bit first. Every eighth bit completes a byte. A completed byte with `ser_dc`=1 appears on `pix_byte` with `pix_valid` high.
- R2: While `ser_csn` is high, clock edges shift nothing. A rise of `ser_csn` discards any partial byte, so the next byte starts fresh.
- R3: After reset the registers hold these values: display off, mode 0, range 0, contrast 00h, column window 00h..3Fh, row window 00h..4Fh, remap 00h, start line 00h, offset 00h, multiplex 4Fh, converter 03h, phase 53h, row period 25h, clock divide 02h, precharge 11h, vcomh 11h, segment low 0Eh. Grey table byte 0 is 01h and bytes 1..7 are 11h.
- R4: The opcodes 81h, A0h, A1h, A2h, A8h, ADh, B1h, B2h, B3h, BCh, BEh and BFh each take one argument byte, which is stored unmodified. They write, in that order: contrast, remap, start line, offset, multiplex, converter, phase, row period, clock divide, precharge, vcomh and segment low.
- R5: Opcode 15h takes two arguments: the column start and the column end, each keeping its low 6 bits. Opcode 75h takes two arguments: the row start and the row end, each keeping its low 7 bits.
- R6: Opcode B8h takes eight arguments, where argument k sets `gray_tbl[8k+7:8k]`. The table changes only when the eighth argument arrives, and then all eight bytes change together.
- R7: Opcodes 84h, 85h and 86h set `cur_range` to 0, 1 and 2 (quarter, half, full). Exactly one range is in force at any time.
- R8: AEh clears `disp_on` and AFh sets it. A4h, A5h, A6h and A7h set `disp_mode` to 0 (normal), 1 (all on), 2 (all off) and 3 (inverse).
- R9: E3h, and any opcode not named here, changes no register. The next command byte is parsed as a new opcode.
- R10: A byte with `ser_dc`=1 that arrives while arguments are pending aborts the command. No register changes, the byte is passed out as pixel data, and the next command byte is an opcode.
- R11: `pix_valid` is high for exactly one cycle per pixel byte. It never rises for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Link select, active low |
| ser_clk | input | 1 | Link serial clock |
| ser_dat | input | 1 | Link serial data |
| ser_dc | input | 1 | Byte type: 0 command, 1 pixel data |
| pix_valid | output | 1 | One-cycle pixel byte strobe |
| pix_byte | output | 8 | Pixel byte |
| disp_on | output | 1 | Display enabled |
| disp_mode | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| cur_range | output | 2 | 0 quarter, 1 half, 2 full |
| contrast | output | 8 | Contrast setting |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| remap | output | 8 | Address remap flags |
| start_line | output | 8 | Memory start line |
| disp_offset | output | 8 | Vertical offset |
| mux_ratio | output | 8 | Multiplex ratio |
| dcdc_cfg | output | 8 | Converter setting |
| phase_len | output | 8 | Drive phase lengths |
| row_period | output | 8 | Clocks per row |
| clk_div | output | 8 | Clock divide and frequency |
| precharge | output | 8 | Precharge level |
| vcomh | output | 8 | Common high level |
| seg_low | output | 8 | Segment low level |
| gray_tbl | output | 64 | Eight grey-level bytes, byte k at bits 8k+7:8k |

## Verification
Pixel bytes are sent with the patterns 00h, FFh, A5h and 5Ah. These show whether the bit order is correct, whether any bit is stuck, and whether a bit is lost or repeated in the shift.

Commands are sent with zero, one, two and eight arguments, and the two-argument commands carry masked high bits. This shows whether each opcode's argument count and destination are right.

Some command sequences are cut short by a pixel byte, and some bytes are preceded by a partial byte or by clocks sent while the link is deselected. These show whether the receiver drops half-received work rather than applying it, while still passing on the data that follows.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_ARGS = 8;
    localparam int CNT_W    = $clog2(MAX_ARGS + 1);
    localparam int COL_W    = 6;
    localparam int ROW_W    = 7;

    typedef enum logic [0:0] {P_OPCODE, P_ARGS} parse_state_e;
    typedef enum logic [1:0] {MODE_NORMAL, MODE_ALL_ON, MODE_ALL_OFF, MODE_INVERSE} disp_mode_e;
    typedef enum logic [1:0] {RANGE_QUARTER, RANGE_HALF, RANGE_FULL} cur_range_e;

    localparam logic [7:0] OP_COL_WIN  = 8'h15;
    localparam logic [7:0] OP_ROW_WIN  = 8'h75;
    localparam logic [7:0] OP_CONTRAST = 8'h81;
    localparam logic [7:0] OP_RANGE_Q  = 8'h84;
    localparam logic [7:0] OP_RANGE_H  = 8'h85;
    localparam logic [7:0] OP_RANGE_F  = 8'h86;
    localparam logic [7:0] OP_REMAP    = 8'hA0;
    localparam logic [7:0] OP_START    = 8'hA1;
    localparam logic [7:0] OP_OFFSET   = 8'hA2;
    localparam logic [7:0] OP_MODE_NRM = 8'hA4;
    localparam logic [7:0] OP_MODE_ON  = 8'hA5;
    localparam logic [7:0] OP_MODE_OFF = 8'hA6;
    localparam logic [7:0] OP_MODE_INV = 8'hA7;
    localparam logic [7:0] OP_MUX      = 8'hA8;
    localparam logic [7:0] OP_DCDC     = 8'hAD;
    localparam logic [7:0] OP_DISP_OFF = 8'hAE;
    localparam logic [7:0] OP_DISP_ON  = 8'hAF;
    localparam logic [7:0] OP_PHASE    = 8'hB1;
    localparam logic [7:0] OP_ROWPER   = 8'hB2;
    localparam logic [7:0] OP_CLKDIV   = 8'hB3;
    localparam logic [7:0] OP_GRAY     = 8'hB8;
    localparam logic [7:0] OP_PRECHG   = 8'hBC;
    localparam logic [7:0] OP_VCOMH    = 8'hBE;
    localparam logic [7:0] OP_SEGLOW   = 8'hBF;

    function automatic logic [CNT_W-1:0] arg_count(input logic [7:0] op);
        logic [CNT_W-1:0] n;
        case (op)
            OP_COL_WIN, OP_ROW_WIN: n = CNT_W'(2);
            OP_GRAY:                n = CNT_W'(MAX_ARGS);
            OP_CONTRAST, OP_REMAP, OP_START, OP_OFFSET, OP_MUX, OP_DCDC,
            OP_PHASE, OP_ROWPER, OP_CLKDIV, OP_PRECHG, OP_VCOMH, OP_SEGLOW:
                                    n = CNT_W'(1);
            default:                n = '0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int               W       = 4,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         csn_s,
    input  logic         sclk_s,
    input  logic         dat_s,
    input  logic         dc_s,
    output logic         byte_vld,
    output logic [W-1:0] byte_dat,
    output logic         byte_dc
);
    localparam int BIT_W = $clog2(W);

    logic             sclk_prev;
    logic             sclk_rise;
    logic [BIT_W-1:0] bit_cnt;
    logic [W-1:0]     shift_q;
    logic [W-1:0]     shift_nx;

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign shift_nx  = {shift_q[W-2:0], dat_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            bit_cnt   <= '0;
            shift_q   <= '0;
            byte_vld  <= 1'b0;
            byte_dat  <= '0;
            byte_dc   <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            byte_vld  <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shift_q <= shift_nx;
                if (bit_cnt == BIT_W'(W-1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                    byte_dat <= shift_nx;
                    byte_dc  <= dc_s;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
    import disp_rx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_vld,
    input  logic [BYTE_W-1:0]          byte_dat,
    input  logic                       byte_dc,
    output logic                       pix_valid,
    output logic [BYTE_W-1:0]          pix_byte,
    output logic                       cmd_commit,
    output logic [BYTE_W-1:0]          cmd_op,
    output logic [MAX_ARGS*BYTE_W-1:0] cmd_args
);
    localparam int IDX_W = $clog2(MAX_ARGS);

    parse_state_e      state_q, state_d;
    logic [BYTE_W-1:0] op_q;
    logic [CNT_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] args_q [MAX_ARGS];
    logic [CNT_W-1:0]  new_cnt;

    assign new_cnt = arg_count(byte_dat);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_OPCODE: if (byte_vld && !byte_dc && new_cnt != '0) state_d = P_ARGS;
            P_ARGS:   if (byte_vld && (byte_dc || left_q == CNT_W'(1))) state_d = P_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_OPCODE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid  <= 1'b0;
            pix_byte   <= '0;
            cmd_commit <= 1'b0;
            cmd_op     <= '0;
            op_q       <= '0;
            left_q     <= '0;
            idx_q      <= '0;
            for (int k = 0; k < MAX_ARGS; k++) args_q[k] <= '0;
        end else begin
            pix_valid  <= 1'b0;
            cmd_commit <= 1'b0;
            if (byte_vld) begin
                if (byte_dc) begin
                    pix_valid <= 1'b1;
                    pix_byte  <= byte_dat;
                end else begin
                    unique case (state_q)
                        P_OPCODE: begin
                            op_q   <= byte_dat;
                            left_q <= new_cnt;
                            idx_q  <= '0;
                            if (new_cnt == '0) begin
                                cmd_commit <= 1'b1;
                                cmd_op     <= byte_dat;
                            end
                        end
                        P_ARGS: begin
                            args_q[idx_q] <= byte_dat;
                            idx_q         <= idx_q + 1'b1;
                            left_q        <= left_q - 1'b1;
                            if (left_q == CNT_W'(1)) begin
                                cmd_commit <= 1'b1;
                                cmd_op     <= op_q;
                            end
                        end
                    endcase
                end
            end
        end
    end

    generate
        for (genvar k = 0; k < MAX_ARGS; k++) begin : g_args
            assign cmd_args[k*BYTE_W +: BYTE_W] = args_q[k];
        end
    endgenerate
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import disp_rx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_commit,
    input  logic [BYTE_W-1:0]          cmd_op,
    input  logic [MAX_ARGS*BYTE_W-1:0] cmd_args,
    output logic                       disp_on,
    output logic [1:0]                 disp_mode,
    output logic [1:0]                 cur_range,
    output logic [7:0]                 contrast,
    output logic [COL_W-1:0]           col_start,
    output logic [COL_W-1:0]           col_end,
    output logic [ROW_W-1:0]           row_start,
    output logic [ROW_W-1:0]           row_end,
    output logic [7:0]                 remap,
    output logic [7:0]                 start_line,
    output logic [7:0]                 disp_offset,
    output logic [7:0]                 mux_ratio,
    output logic [7:0]                 dcdc_cfg,
    output logic [7:0]                 phase_len,
    output logic [7:0]                 row_period,
    output logic [7:0]                 clk_div,
    output logic [7:0]                 precharge,
    output logic [7:0]                 vcomh,
    output logic [7:0]                 seg_low,
    output logic [MAX_ARGS*BYTE_W-1:0] gray_tbl
);
    logic [7:0] a0, a1;
    assign a0 = cmd_args[7:0];
    assign a1 = cmd_args[15:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_on     <= 1'b0;
            disp_mode   <= MODE_NORMAL;
            cur_range   <= RANGE_QUARTER;
            contrast    <= 8'h00;
            col_start   <= '0;
            col_end     <= COL_W'(8'h3F);
            row_start   <= '0;
            row_end     <= ROW_W'(8'h4F);
            remap       <= 8'h00;
            start_line  <= 8'h00;
            disp_offset <= 8'h00;
            mux_ratio   <= 8'h4F;
            dcdc_cfg    <= 8'h03;
            phase_len   <= 8'h53;
            row_period  <= 8'h25;
            clk_div     <= 8'h02;
            precharge   <= 8'h11;
            vcomh       <= 8'h11;
            seg_low     <= 8'h0E;
            for (int k = 0; k < MAX_ARGS; k++)
                gray_tbl[k*BYTE_W +: BYTE_W] <= (k == 0) ? 8'h01 : 8'h11;
        end else if (cmd_commit) begin
            case (cmd_op)
                OP_COL_WIN:  begin col_start <= a0[COL_W-1:0]; col_end <= a1[COL_W-1:0]; end
                OP_ROW_WIN:  begin row_start <= a0[ROW_W-1:0]; row_end <= a1[ROW_W-1:0]; end
                OP_CONTRAST: contrast    <= a0;
                OP_REMAP:    remap       <= a0;
                OP_START:    start_line  <= a0;
                OP_OFFSET:   disp_offset <= a0;
                OP_MUX:      mux_ratio   <= a0;
                OP_DCDC:     dcdc_cfg    <= a0;
                OP_PHASE:    phase_len   <= a0;
                OP_ROWPER:   row_period  <= a0;
                OP_CLKDIV:   clk_div     <= a0;
                OP_PRECHG:   precharge   <= a0;
                OP_VCOMH:    vcomh       <= a0;
                OP_SEGLOW:   seg_low     <= a0;
                OP_GRAY:     gray_tbl    <= cmd_args;
                OP_RANGE_Q:  cur_range   <= RANGE_QUARTER;
                OP_RANGE_H:  cur_range   <= RANGE_HALF;
                OP_RANGE_F:  cur_range   <= RANGE_FULL;
                OP_MODE_NRM: disp_mode   <= MODE_NORMAL;
                OP_MODE_ON:  disp_mode   <= MODE_ALL_ON;
                OP_MODE_OFF: disp_mode   <= MODE_ALL_OFF;
                OP_MODE_INV: disp_mode   <= MODE_INVERSE;
                OP_DISP_OFF: disp_on     <= 1'b0;
                OP_DISP_ON:  disp_on     <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
    import disp_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_csn,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_dc,
    output logic        pix_valid,
    output logic [7:0]  pix_byte,
    output logic        disp_on,
    output logic [1:0]  disp_mode,
    output logic [1:0]  cur_range,
    output logic [7:0]  contrast,
    output logic [5:0]  col_start,
    output logic [5:0]  col_end,
    output logic [6:0]  row_start,
    output logic [6:0]  row_end,
    output logic [7:0]  remap,
    output logic [7:0]  start_line,
    output logic [7:0]  disp_offset,
    output logic [7:0]  mux_ratio,
    output logic [7:0]  dcdc_cfg,
    output logic [7:0]  phase_len,
    output logic [7:0]  row_period,
    output logic [7:0]  clk_div,
    output logic [7:0]  precharge,
    output logic [7:0]  vcomh,
    output logic [7:0]  seg_low,
    output logic [63:0] gray_tbl
);
    logic [3:0]                 pins_s;
    logic                       csn_s, sclk_s, dat_s, dc_s;
    logic                       byte_vld, byte_dc;
    logic [BYTE_W-1:0]          byte_dat;
    logic                       cmd_commit;
    logic [BYTE_W-1:0]          cmd_op;
    logic [MAX_ARGS*BYTE_W-1:0] cmd_args;

    pin_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_csn, ser_clk, ser_dat, ser_dc}),
        .q(pins_s)
    );
    assign {csn_s, sclk_s, dat_s, dc_s} = pins_s;

    byte_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .csn_s(csn_s), .sclk_s(sclk_s), .dat_s(dat_s), .dc_s(dc_s),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_dc(byte_dc)
    );

    cmd_parser u_parse (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_dc(byte_dc),
        .pix_valid(pix_valid), .pix_byte(pix_byte),
        .cmd_commit(cmd_commit), .cmd_op(cmd_op), .cmd_args(cmd_args)
    );

    cfg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .cmd_commit(cmd_commit), .cmd_op(cmd_op), .cmd_args(cmd_args),
        .disp_on(disp_on), .disp_mode(disp_mode), .cur_range(cur_range),
        .contrast(contrast), .col_start(col_start), .col_end(col_end),
        .row_start(row_start), .row_end(row_end), .remap(remap),
        .start_line(start_line), .disp_offset(disp_offset),
        .mux_ratio(mux_ratio), .dcdc_cfg(dcdc_cfg), .phase_len(phase_len),
        .row_period(row_period), .clk_div(clk_div), .precharge(precharge),
        .vcomh(vcomh), .seg_low(seg_low), .gray_tbl(gray_tbl)
    );
endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csn_s,
    input logic        byte_vld,
    input logic        byte_dc,
    input logic        pix_valid,
    input logic        cmd_commit,
    input logic [1:0]  cur_range,
    input logic [63:0] gray_tbl
);
    // R2: nothing completes after the link is deselected
    a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !byte_vld);

    // R1: a completed data-type byte yields a strobe next cycle
    a_r1_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_dc) |=> pix_valid);

    // R11: the strobe lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    // R10: a data byte never applies a command
    a_r10_data_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !cmd_commit);

    // R6: the grey table only changes right after a commit
    a_r6_gray_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_commit |=> $stable(gray_tbl));

    // R7: only the three legal range codes occur
    a_r7_range_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_range != 2'd3);
endmodule

bind disp_cmd_rx disp_cmd_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .byte_vld(byte_vld),
    .byte_dc(byte_dc), .pix_valid(pix_valid), .cmd_commit(cmd_commit),
    .cur_range(cur_range), .gray_tbl(gray_tbl)
);

// File: tb/tb_disp_cmd_rx.sv
module tb_disp_cmd_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 0, rst_n = 0;
    logic ser_csn = 1, ser_clk = 0, ser_dat = 0, ser_dc = 0;
    logic pix_valid; logic [7:0] pix_byte;
    logic disp_on; logic [1:0] disp_mode, cur_range;
    logic [7:0] contrast; logic [5:0] col_start, col_end; logic [6:0] row_start, row_end;
    logic [7:0] remap, start_line, disp_offset, mux_ratio, dcdc_cfg, phase_len;
    logic [7:0] row_period, clk_div, precharge, vcomh, seg_low;
    logic [63:0] gray_tbl;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_cmd_rx dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic dc);
        ser_dat = b; ser_dc = dc;
        repeat (HALF_BIT) @(negedge clk);
        ser_clk = 1;
        repeat (HALF_BIT) @(negedge clk);
        ser_clk = 0;
    endtask

    task automatic send_byte(input logic dc, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i], dc);
        if (dc) exp_q.push_back(b);
    endtask

    task automatic sel();
        ser_csn = 0; repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF_BIT) @(negedge clk); ser_csn = 1; repeat (12) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op, input logic [7:0] a);
        sel(); send_byte(0, op); send_byte(0, a); desel();
    endtask

    // monitor: pops expected pixel bytes as strobes appear
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R11 unexpected strobe actual=%0h expected=none", pix_byte);
            end else check("R1 pixel byte", {56'd0, pix_byte}, {56'd0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [63:0] g_new;
        repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);

        // R3 reset values
        check("R3 disp_on", disp_on, 0);
        check("R3 mode", disp_mode, 0);
        check("R3 range", cur_range, 0);
        check("R3 contrast", contrast, 8'h00);
        check("R3 col window", {col_start, col_end}, {6'h00, 6'h3F});
        check("R3 row window", {row_start, row_end}, {7'h00, 7'h4F});
        check("R3 mux", mux_ratio, 8'h4F);
        check("R3 phase/rowper/clkdiv", {phase_len, row_period, clk_div}, 24'h532502);
        check("R3 analog", {dcdc_cfg, precharge, vcomh, seg_low}, 32'h0311110E);
        check("R3 gray", gray_tbl, 64'h1111111111111101);

        // R1 R11 pixel patterns
        sel();
        send_byte(1, 8'h00); send_byte(1, 8'hFF); send_byte(1, 8'hA5); send_byte(1, 8'h5A);
        desel();
        check("R11 queue drained", exp_q.size(), 0);

        // R4 single-argument commands
        cmd1(8'h81, 8'h33); check("R4 contrast", contrast, 8'h33);
        cmd1(8'hA0, 8'h52); check("R4 remap", remap, 8'h52);
        cmd1(8'hA1, 8'h07); check("R4 start line", start_line, 8'h07);
        cmd1(8'hA2, 8'h40); check("R4 offset", disp_offset, 8'h40);
        cmd1(8'hA8, 8'h3F); check("R4 mux", mux_ratio, 8'h3F);
        cmd1(8'hAD, 8'h02); check("R4 dcdc", dcdc_cfg, 8'h02);
        cmd1(8'hB1, 8'h22); check("R4 phase", phase_len, 8'h22);
        cmd1(8'hB2, 8'h46); check("R4 row period", row_period, 8'h46);
        cmd1(8'hB3, 8'h91); check("R4 clk div", clk_div, 8'h91);
        cmd1(8'hBC, 8'h1F); check("R4 precharge", precharge, 8'h1F);
        cmd1(8'hBE, 8'h0D); check("R4 vcomh", vcomh, 8'h0D);
        cmd1(8'hBF, 8'h02); check("R4 seg low", seg_low, 8'h02);

        // R5 two-argument windows with masking
        sel(); send_byte(0, 8'h15); send_byte(0, 8'hC5); send_byte(0, 8'hFF); desel();
        check("R5 col window", {col_start, col_end}, {6'h05, 6'h3F});
        sel(); send_byte(0, 8'h75); send_byte(0, 8'h90); send_byte(0, 8'h2A); desel();
        check("R5 row window", {row_start, row_end}, {7'h10, 7'h2A});

        // R6 full table load
        g_new = 64'h7766554433221107;
        sel(); send_byte(0, 8'hB8);
        for (int k = 0; k < 8; k++) send_byte(0, g_new[k*8 +: 8]);
        desel();
        check("R6 gray loaded", gray_tbl, g_new);

        // R6 R10 table load cut short by pixel byte
        sel(); send_byte(0, 8'hB8);
        send_byte(0, 8'hAA); send_byte(0, 8'hBB); send_byte(0, 8'hCC);
        send_byte(1, 8'h3C); desel();
        check("R6 R10 gray unchanged after abort", gray_tbl, g_new);
        check("R10 abort byte delivered", exp_q.size(), 0);

        // R10 single-arg abort then new opcode
        sel(); send_byte(0, 8'h81); send_byte(1, 8'h77); send_byte(0, 8'h81); send_byte(0, 8'h22); desel();
        check("R10 contrast after abort+reissue", contrast, 8'h22);

        // R7 ranges
        sel(); send_byte(0, 8'h85); desel(); check("R7 half", cur_range, 1);
        sel(); send_byte(0, 8'h86); desel(); check("R7 full", cur_range, 2);
        sel(); send_byte(0, 8'h84); desel(); check("R7 quarter", cur_range, 0);

        // R8 on/off and modes
        sel(); send_byte(0, 8'hAF); desel(); check("R8 on", disp_on, 1);
        sel(); send_byte(0, 8'hA7); desel(); check("R8 inverse", disp_mode, 3);
        sel(); send_byte(0, 8'hA5); desel(); check("R8 all on", disp_mode, 1);
        sel(); send_byte(0, 8'hA6); desel(); check("R8 all off", disp_mode, 2);
        sel(); send_byte(0, 8'hA4); desel(); check("R8 normal", disp_mode, 0);
        sel(); send_byte(0, 8'hAE); desel(); check("R8 off", disp_on, 0);

        // R9 no-op and unknown opcodes; next byte is an opcode
        sel(); send_byte(0, 8'hE3); send_byte(0, 8'h00); send_byte(0, 8'h81); send_byte(0, 8'h5E); desel();
        check("R9 contrast after nop", contrast, 8'h5E);
        check("R9 others unchanged", {remap, mux_ratio, phase_len, cur_range, 6'd0, disp_on}, {8'h52, 8'h3F, 8'h22, 2'd0, 6'd0, 1'b0});

        // R2 clocks while deselected shift nothing
        ser_csn = 1;
        for (int i = 0; i < 5; i++) send_bit(1, 1);
        sel(); send_byte(1, 8'h81); desel();
        // R2 partial byte discarded on deselect
        sel();
        for (int i = 0; i < 5; i++) send_bit(1, 1);
        ser_csn = 1; repeat (8) @(negedge clk);
        sel(); send_byte(1, 8'h18); desel();
        check("R2 no leftover strobes", exp_q.size(), 0);
        check("R2 contrast untouched", contrast, 8'h5E);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule